// File: doc/BRIEF.md
# Asynchronous static memory strobe sequencer

This block runs one read or one write at a time on an asynchronous static memory behind a single chip select. A requester holds a level request together with address, write data, byte enables and direction, and gets a one-cycle acknowledge when the access is over. For reads, the captured data is presented in the acknowledge cycle. The memory side carries a held address, an output-enabled write data bus, and active-low chip select, read strobe, write strobe and per-lane strobes. All strobes idle high.

Each access follows a cycle counter that starts at 0 in the first access cycle, when the address becomes valid. Chip select and the direction strobe each have their own setup count (the first counter value at which the strobe is low) and pulse count (how many values it stays low). These counts are separate for reads and writes. A total cycle count per direction ends the access. Mode bits choose which strobe edge captures read data and which strobe edge starts driving write data. They also pick a wait-input behaviour, pick byte-select or byte-write lane signalling, and control a bus turnaround after reads.

Settings are written through an 8-bit indexed configuration port. The block copies them at the start of every access, so a write that lands mid-access only affects later accesses.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever no access is running, chip select, read strobe, write strobe and all lane strobes are high, `memDataOe` is 0 and `reqAck` is 0.
- R2: During an access, a strobe is low at counter value t exactly when its pulse count p is nonzero and setup s <= t < s+p. Reads use the chip-select read counts and the read-strobe counts, and the write strobe stays high. Writes use the chip-select write counts and the write-strobe counts, and the read strobe stays high.
- R3: With no stall, an access occupies exactly C cycles (C = the direction's total count, 0 treated as 1). `reqAck` comes in the cycle right after the last one. Any strobe window that reaches past the last cycle is cut off there.
- R4: `reqAck` is high for exactly one cycle per access. For reads, `rdData` is valid in that cycle. `memAddr` holds the request address throughout the access.
- R5: Read data is captured at the clock edge that ends the last low cycle of the capture strobe. Mode bit 0 = 0 selects chip select. Mode bit 0 = 1 selects the read strobe.
- R6: On writes, `memDataOe` rises in the first low cycle of the launch strobe and stays high to the end of the access. `memDataOut` carries the write data while it is high. Mode bit 1 = 0 selects chip select. Mode bit 1 = 1 selects the write strobe.
- R7: Wait mode (mode bits 3:2) 0 or the reserved value 1 ignores `memWait`.
- R8: Wait mode 2 (frozen) stalls the cycle counter and holds every strobe in every access cycle whose ending edge sees `memWait` high.
- R9: Wait mode 3 (ready) stalls only in the final low cycle of the direction strobe, holding that strobe low until `memWait` is seen low.
- R10: Lane mode 0 (mode bit 4 = 0): during an access, `memLaneN[i]` is low exactly when request byte enable i is set. The single `memWeN` carries the write pulse.
- R11: Lane mode 1 (mode bit 4 = 1): `memWeN` stays high. On writes, `memLaneN[i]` is low when the write strobe window is active and byte enable i is set. On reads, every lane follows the read strobe.
- R12: After a read, the next access starts only after F+1 idle cycles beyond the normal two, where F is the float field (index 11, bits 3:0). When chip select spans whole accesses, chip select stays high for F+3 cycles between them. After a write, or with the float skipped, the gap is 2.
- R13: With the float-skip bit set (mode bit 5), the float wait after a read applies only when the next access is a write.
- R14: Configuration index map: 0 read total, 1 write total, 2/3 chip-select read setup/pulse, 4/5 read-strobe setup/pulse, 6/7 chip-select write setup/pulse, 8/9 write-strobe setup/pulse, 10 mode, 11 float. Reset gives totals and pulses of 4 and zeros elsewhere. Settings are copied at access start, so a write made mid-access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write enable |
| cfgIdx | input | 4 | Configuration register index |
| cfgData | input | 8 | Configuration write value |
| req | input | 1 | Access request level, held until acknowledge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWrData | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables |
| reqAck | output | 1 | One-cycle access completion |
| rdData | output | DATA_W | Captured read data |
| memAddr | output | ADDR_W | Memory address |
| memDataOut | output | DATA_W | Memory write data |
| memDataOe | output | 1 | Write data drive enable |
| memDataIn | input | DATA_W | Memory read data |
| memWait | input | 1 | Memory wait request, active high |
| memCsN | output | 1 | Chip select, active low |
| memRdN | output | 1 | Read strobe, active low |
| memWeN | output | 1 | Write strobe, active low |
| memLaneN | output | DATA_W/8 | Byte-lane strobes, active low |

## Verification
The bound checker watches, on every cycle, the relations that hold at any instant. The acknowledge is one cycle wide, and all strobes are high in that cycle. The read and write strobes are never low together. The data bus is never driven while the read strobe is low. In byte-write mode the single write strobe stays parked high and read lanes follow the read strobe. The directed scenarios are the only way to show the counted behaviour. This covers window placement and truncation, the edge chosen for capture and launch, the length of stalls under each wait mode, the float gap with and without the skip bit, and the copy of settings at access start.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int CNT_W   = 8;
  localparam int FLOAT_W = 5;

  localparam logic [1:0] WAIT_FROZEN = 2'd2;
  localparam logic [1:0] WAIT_READY  = 2'd3;

  typedef struct packed {
    logic [CNT_W-1:0] rdCycle;
    logic [CNT_W-1:0] wrCycle;
    logic [CNT_W-1:0] csRdSetup;
    logic [CNT_W-1:0] csRdPulse;
    logic [CNT_W-1:0] rdSetup;
    logic [CNT_W-1:0] rdPulse;
    logic [CNT_W-1:0] csWrSetup;
    logic [CNT_W-1:0] csWrPulse;
    logic [CNT_W-1:0] weSetup;
    logic [CNT_W-1:0] wePulse;
    logic             rdEdgeSel;
    logic             wrEdgeSel;
    logic [1:0]       waitMode;
    logic             byteWrite;
    logic             floatOpt;
    logic [3:0]       floatCycles;
  } cfg_t;

  // control to datapath strobe bundle
  typedef struct packed {
    logic accept;
    logic busy;
    logic csAct;
    logic rdAct;
    logic weAct;
    logic oeAct;
    logic capture;
    logic isWrite;
    logic byteWrite;
  } strobe_s;
endpackage

// File: rtl/sram_strobe_ctl.sv
module sram_strobe_ctl
  import sram_strobe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  logic    req,
  input  logic    reqWrite,
  input  logic    memWait,
  output strobe_s stb,
  output logic    reqAck
);
  timeunit 1ns; timeprecision 100ps;

  localparam int SUM_W = CNT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_FIN} state_e;

  state_e             state;
  cfg_t               act;
  logic               isWr;
  logic [CNT_W-1:0]   tCnt;
  logic [FLOAT_W-1:0] floatCnt;

  function automatic logic inWin(input logic [CNT_W-1:0] t,
                                 input logic [CNT_W-1:0] s,
                                 input logic [CNT_W-1:0] p);
    logic [SUM_W-1:0] e;
    e = {1'b0, s} + {1'b0, p};
    return (p != '0) && (t >= s) && ({1'b0, t} < e);
  endfunction

  function automatic logic [SUM_W-1:0] endPt(input logic [CNT_W-1:0] s,
                                             input logic [CNT_W-1:0] p,
                                             input logic [CNT_W-1:0] last);
    logic [SUM_W-1:0] e;
    e = {1'b0, s} + {1'b0, p} - SUM_W'(1);
    return (e > {1'b0, last}) ? {1'b0, last} : e;
  endfunction

  logic [CNT_W-1:0] cyc, lastT, csS, csP, drS, drP, capS, capP, outS, outP;
  logic inAcc, pulseEnd, stall, advance, done, capHit, accept;

  always_comb begin
    cyc   = isWr ? act.wrCycle : act.rdCycle;
    lastT = (cyc == '0) ? '0 : cyc - CNT_W'(1);
    csS   = isWr ? act.csWrSetup : act.csRdSetup;
    csP   = isWr ? act.csWrPulse : act.csRdPulse;
    drS   = isWr ? act.weSetup : act.rdSetup;
    drP   = isWr ? act.wePulse : act.rdPulse;
    capS  = act.rdEdgeSel ? act.rdSetup : act.csRdSetup;
    capP  = act.rdEdgeSel ? act.rdPulse : act.csRdPulse;
    outS  = act.wrEdgeSel ? act.weSetup : act.csWrSetup;
    outP  = act.wrEdgeSel ? act.wePulse : act.csWrPulse;

    inAcc    = (state == S_ACC);
    pulseEnd = (drP != '0) && ({1'b0, tCnt} == endPt(drS, drP, lastT));
    stall    = inAcc && memWait &&
               ((act.waitMode == WAIT_FROZEN) ||
                ((act.waitMode == WAIT_READY) && pulseEnd));
    advance  = inAcc && !stall;
    done     = advance && (tCnt == lastT);
    capHit   = inWin(tCnt, capS, capP) &&
               ((({1'b0, tCnt} + SUM_W'(1)) == ({1'b0, capS} + {1'b0, capP})) ||
                (tCnt == lastT));
    accept   = (state == S_IDLE) && req &&
               ((floatCnt == '0) || (act.floatOpt && !reqWrite));

    stb.accept    = accept;
    stb.busy      = inAcc;
    stb.csAct     = inAcc && inWin(tCnt, csS, csP);
    stb.rdAct     = inAcc && !isWr && inWin(tCnt, drS, drP);
    stb.weAct     = inAcc && isWr && inWin(tCnt, drS, drP);
    stb.oeAct     = inAcc && isWr && (outP != '0) && (tCnt >= outS);
    stb.capture   = !isWr && advance && capHit;
    stb.isWrite   = isWr;
    stb.byteWrite = act.byteWrite;
    reqAck        = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      act      <= '0;
      isWr     <= 1'b0;
      tCnt     <= '0;
      floatCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          act   <= cfg;
          isWr  <= reqWrite;
          tCnt  <= '0;
          state <= S_ACC;
        end
        S_ACC: begin
          if (done)         state <= S_FIN;
          else if (advance) tCnt  <= tCnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase

      if (done && !isWr)        floatCnt <= FLOAT_W'(act.floatCycles) + FLOAT_W'(2);
      else if (accept)          floatCnt <= '0;
      else if (floatCnt != '0)  floatCnt <= floatCnt - FLOAT_W'(1);
    end
  end
endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [3:0]        cfgIdx,
  input  logic [CNT_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] memDataIn,
  input  strobe_s           stb,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCsN,
  output logic              memRdN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN
);
  timeunit 1ns; timeprecision 100ps;

  logic [LANES-1:0] beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg           <= '0;
      cfg.rdCycle   <= CNT_W'(4);
      cfg.wrCycle   <= CNT_W'(4);
      cfg.csRdPulse <= CNT_W'(4);
      cfg.rdPulse   <= CNT_W'(4);
      cfg.csWrPulse <= CNT_W'(4);
      cfg.wePulse   <= CNT_W'(4);
    end else if (cfgWr) begin
      case (cfgIdx)
        4'd0:  cfg.rdCycle   <= cfgData;
        4'd1:  cfg.wrCycle   <= cfgData;
        4'd2:  cfg.csRdSetup <= cfgData;
        4'd3:  cfg.csRdPulse <= cfgData;
        4'd4:  cfg.rdSetup   <= cfgData;
        4'd5:  cfg.rdPulse   <= cfgData;
        4'd6:  cfg.csWrSetup <= cfgData;
        4'd7:  cfg.csWrPulse <= cfgData;
        4'd8:  cfg.weSetup   <= cfgData;
        4'd9:  cfg.wePulse   <= cfgData;
        4'd10: begin
          cfg.rdEdgeSel <= cfgData[0];
          cfg.wrEdgeSel <= cfgData[1];
          cfg.waitMode  <= cfgData[3:2];
          cfg.byteWrite <= cfgData[4];
          cfg.floatOpt  <= cfgData[5];
        end
        4'd11: cfg.floatCycles <= cfgData[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr    <= '0;
      memDataOut <= '0;
      beQ        <= '0;
      rdData     <= '0;
    end else begin
      if (stb.accept) begin
        memAddr    <= reqAddr;
        memDataOut <= reqWrData;
        beQ        <= reqBe;
      end
      if (stb.capture) rdData <= memDataIn;
    end
  end

  always_comb begin
    memCsN    = ~stb.csAct;
    memRdN    = ~stb.rdAct;
    memWeN    = ~(stb.weAct & ~stb.byteWrite);
    memDataOe = stb.oeAct;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (stb.byteWrite)
        memLaneN[i] = stb.isWrite ? ~(stb.weAct & beQ[i]) : ~stb.rdAct;
      else
        memLaneN[i] = ~(stb.busy & beQ[i]);
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [3:0]        cfgIdx,
  input  logic [7:0]        cfgData,
  input  logic              req,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [LANES-1:0]  reqBe,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  input  logic              memWait,
  output logic              memCsN,
  output logic              memRdN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN
);
  timeunit 1ns; timeprecision 100ps;

  cfg_t    cfg;
  strobe_s stb;

  sram_strobe_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .req(req), .reqWrite(reqWrite),
    .memWait(memWait), .stb(stb), .reqAck(reqAck)
  );

  sram_strobe_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqBe(reqBe),
    .memDataIn(memDataIn), .stb(stb), .cfg(cfg), .rdData(rdData),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memCsN(memCsN), .memRdN(memRdN), .memWeN(memWeN), .memLaneN(memLaneN)
  );
endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk
  import sram_strobe_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqAck,
  input logic             memCsN,
  input logic             memRdN,
  input logic             memWeN,
  input logic             memDataOe,
  input logic [LANES-1:0] memLaneN,
  input strobe_s          stb
);
  timeunit 1ns; timeprecision 100ps;

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R1
  ack_idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (memCsN && memRdN && memWeN && !memDataOe && (&memLaneN)));

  // R2
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWeN));

  // R6
  no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memRdN);

  // R11
  bytewrite_we_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.byteWrite |-> memWeN);

  // R11
  bytewrite_read_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.byteWrite && stb.busy && !stb.isWrite) |-> (memLaneN == {LANES{memRdN}}));
endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .reqAck(reqAck), .memCsN(memCsN), .memRdN(memRdN),
  .memWeN(memWeN), .memDataOe(memDataOe), .memLaneN(memLaneN), .stb(stb)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [3:0]  cfgIdx = '0;
  logic [7:0]  cfgData = '0;
  logic        req = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWrData = '0;
  logic [1:0]  reqBe = '0;
  logic [15:0] memDataIn = '0;
  logic        memWait = 1'b0;
  logic        reqAck, memDataOe, memCsN, memRdN, memWeN;
  logic [15:0] rdData, memAddr, memDataOut;
  logic [1:0]  memLaneN;

  sram_strobe_ctrl u_sram_strobe_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .reqBe(reqBe), .reqAck(reqAck), .rdData(rdData), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .memWait(memWait), .memCsN(memCsN), .memRdN(memRdN), .memWeN(memWeN),
    .memLaneN(memLaneN)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic        trCs[0:63], trRd[0:63], trWe[0:63], trOe[0:63];
  logic [1:0]  trLn[0:63];
  logic [15:0] trAd[0:63], trDo[0:63];
  int          ackAt;
  logic [15:0] gotRd;

  int hiRun = 0;
  int lastGap = 0;
  always @(negedge clk) begin
    if (!rstN) hiRun = 0;
    else if (memCsN) hiRun = hiRun + 1;
    else begin
      if (hiRun > 0) lastGap = hiRun;
      hiRun = 0;
    end
  end

  task automatic chkEq(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgSet(input logic [3:0] idx, input logic [7:0] val);
    cfgWr = 1'b1; cfgIdx = idx; cfgData = val;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runAcc(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int wFrom, input int wTo,
                        input int midIdx, input logic [7:0] midVal);
    req = 1'b1; reqWrite = wr; reqAddr = a; reqWrData = d; reqBe = be;
    memWait = 1'b0; memDataIn = 16'hA000; ackAt = -1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      trCs[k] = memCsN; trRd[k] = memRdN; trWe[k] = memWeN; trOe[k] = memDataOe;
      trLn[k] = memLaneN; trAd[k] = memAddr; trDo[k] = memDataOut;
      if (reqAck) begin
        ackAt = k; gotRd = rdData; req = 1'b0; memWait = 1'b0; cfgWr = 1'b0;
        break;
      end
      memWait = (k >= wFrom) && (k <= wTo);
      memDataIn = 16'hA000 | 16'(k);
      if (midIdx >= 0) begin
        if (k == 1) begin cfgWr = 1'b1; cfgIdx = 4'(midIdx); cfgData = midVal; end
        else cfgWr = 1'b0;
      end
    end
  endtask

  function automatic logic trOf(input int which, input int k);
    case (which)
      0: return trCs[k];
      1: return trRd[k];
      default: return trWe[k];
    endcase
  endfunction

  task automatic chkWin(input string tag, input int which, input int s, input int p, input int cyc);
    int mism = 0;
    for (int k = 0; k < cyc; k++) begin
      logic expLow;
      expLow = (p != 0) && (k >= s) && (k < s + p);
      if (trOf(which, k) !== !expLow) mism++;
    end
    chkEq(tag, mism, 0);
  endtask

  function automatic int lowCount(input int which, input int n);
    int c = 0;
    for (int k = 0; k < n; k++) if (trOf(which, k) == 1'b0) c++;
    return c;
  endfunction

  task automatic tReset();
    chkEq("R1 reset strobes", {memCsN, memRdN, memWeN, memLaneN}, 5'h1F);
    chkEq("R1 reset oe/ack", {memDataOe, reqAck}, 0);
  endtask

  task automatic tReadWindows();
    idle(20);
    cfgSet(2, 1); cfgSet(3, 4); cfgSet(4, 2); cfgSet(5, 2); cfgSet(0, 7); cfgSet(10, 0);
    idle(2);
    runAcc(0, 16'h1234, 0, 2'b11, -1, -1, -1, 0);
    chkWin("R2 read cs window", 0, 1, 4, 7);
    chkWin("R2 read rd window", 1, 2, 2, 7);
    chkEq("R2 read we idle", lowCount(2, 7), 0);
    chkEq("R3 read length", ackAt, 7);
    chkEq("R4 address held", trAd[3], 16'h1234);
    chkEq("R5 capture on cs edge", gotRd, 16'hA004);
    @(negedge clk);
    chkEq("R4 ack single cycle", reqAck, 0);
    idle(20);
    cfgSet(10, 8'h01);
    idle(2);
    runAcc(0, 16'h0042, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R5 capture on rd edge", gotRd, 16'hA003);
  endtask

  task automatic tWriteWindows();
    int oeCnt = 0;
    int badData = 0;
    int badLane = 0;
    idle(20);
    cfgSet(6, 0); cfgSet(7, 3); cfgSet(8, 1); cfgSet(9, 1); cfgSet(1, 5); cfgSet(10, 0);
    idle(2);
    runAcc(1, 16'h0777, 16'hBEEF, 2'b01, -1, -1, -1, 0);
    chkWin("R2 write cs window", 0, 0, 3, 5);
    chkWin("R2 write we window", 2, 1, 1, 5);
    chkEq("R2 write rd idle", lowCount(1, 5), 0);
    chkEq("R3 write length", ackAt, 5);
    for (int k = 0; k < 5; k++) begin
      if (trOe[k]) oeCnt++;
      if (trOe[k] && trDo[k] != 16'hBEEF) badData++;
      if (trLn[k] != 2'b10) badLane++;
    end
    chkEq("R6 oe from cs fall", oeCnt, 5);
    chkEq("R6 write data on bus", badData, 0);
    chkEq("R10 byte-select lanes", badLane, 0);
    idle(20);
    cfgSet(10, 8'h02);
    idle(2);
    runAcc(1, 16'h0777, 16'h5A5A, 2'b11, -1, -1, -1, 0);
    chkEq("R6 oe before we fall", trOe[0], 0);
    chkEq("R6 oe at we fall", {trOe[1], trOe[4]}, 2'b11);
  endtask

  task automatic tTruncZero();
    idle(20);
    cfgSet(2, 0); cfgSet(3, 0); cfgSet(4, 3); cfgSet(5, 10); cfgSet(0, 5); cfgSet(10, 0);
    idle(2);
    runAcc(0, 16'h0001, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R2 zero pulse cs never low", lowCount(0, 6), 0);
    chkWin("R3 truncated rd window", 1, 3, 10, 5);
    chkEq("R3 truncated length", ackAt, 5);
  endtask

  task automatic tWaitModes();
    idle(20);
    cfgSet(2, 0); cfgSet(3, 6); cfgSet(4, 1); cfgSet(5, 2); cfgSet(0, 6); cfgSet(10, 8'h00);
    idle(2);
    runAcc(0, 0, 0, 2'b11, 0, 4, -1, 0);
    chkEq("R7 wait ignored mode 0", ackAt, 6);
    idle(20); cfgSet(10, 8'h04); idle(2);
    runAcc(0, 0, 0, 2'b11, 0, 4, -1, 0);
    chkEq("R7 wait ignored reserved mode", ackAt, 6);
    idle(20); cfgSet(10, 8'h08); idle(2);
    runAcc(0, 0, 0, 2'b11, 1, 3, -1, 0);
    chkEq("R8 frozen length", ackAt, 9);
    chkEq("R8 frozen rd stretch", lowCount(1, 9), 5);
    idle(20); cfgSet(10, 8'h0C); idle(2);
    runAcc(0, 0, 0, 2'b11, 0, 4, -1, 0);
    chkEq("R9 ready length", ackAt, 9);
    chkEq("R9 ready rd held", lowCount(1, 9), 5);
    chkEq("R9 rd held through k5", {trRd[1], trRd[5], trRd[6]}, 3'b001);
  endtask

  task automatic tByteWrite();
    int badLn = 0;
    idle(20);
    cfgSet(6, 0); cfgSet(7, 4); cfgSet(8, 1); cfgSet(9, 2); cfgSet(1, 4);
    cfgSet(4, 1); cfgSet(5, 2); cfgSet(0, 4); cfgSet(10, 8'h10);
    idle(2);
    runAcc(1, 0, 16'h1111, 2'b01, -1, -1, -1, 0);
    chkEq("R11 single we parked", lowCount(2, 4), 0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] exp;
      exp = (k >= 1 && k < 3) ? 2'b10 : 2'b11;
      if (trLn[k] != exp) badLn++;
    end
    chkEq("R11 per-lane write strobes", badLn, 0);
    idle(20);
    runAcc(0, 0, 0, 2'b01, -1, -1, -1, 0);
    chkEq("R11 read lanes follow rd", {trLn[0], trLn[1], trLn[2], trLn[3]}, 8'b11_00_00_11);
  endtask

  task automatic tFloat();
    idle(20);
    cfgSet(2, 0); cfgSet(3, 4); cfgSet(4, 0); cfgSet(5, 4); cfgSet(0, 4);
    cfgSet(6, 0); cfgSet(7, 4); cfgSet(8, 0); cfgSet(9, 4); cfgSet(1, 4);
    cfgSet(11, 3); cfgSet(10, 8'h00);
    idle(2);
    runAcc(0, 0, 0, 2'b11, -1, -1, -1, 0);
    runAcc(0, 0, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R12 read-read float gap", lastGap, 6);
    runAcc(1, 0, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R12 read-write float gap", lastGap, 6);
    runAcc(0, 0, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R12 write-read no float", lastGap, 2);
    idle(20);
    cfgSet(10, 8'h20);
    idle(2);
    runAcc(0, 0, 0, 2'b11, -1, -1, -1, 0);
    runAcc(0, 0, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R13 skip float read-read", lastGap, 2);
    runAcc(1, 0, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R13 keep float read-write", lastGap, 6);
  endtask

  task automatic tSnapshot();
    idle(20);
    cfgSet(0, 4); cfgSet(10, 0);
    idle(2);
    runAcc(0, 0, 0, 2'b11, -1, -1, 0, 8'd9);
    chkEq("R14 mid-access write ignored", ackAt, 4);
    idle(20);
    runAcc(0, 0, 0, 2'b11, -1, -1, -1, 0);
    chkEq("R14 new total applied", ackAt, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReadWindows();
    tWriteWindows();
    tTruncZero();
    tWaitModes();
    tByteWrite();
    tFloat();
    tSnapshot();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule